// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter with Capture and Pulse Generation

This block is a 16-bit up-counter with two 16-bit data registers, called the period register and the second register, programmed over an 8-bit host bus. In its four operating modes the counter advances on different sources. Interval mode uses the prescaler tick. Event mode uses a synchronised rising edge of an external pin. Gated mode uses the prescaler tick, but only while a synchronised gate input is high. Pulse mode uses the prescaler tick and drives a pulse output. In every mode a match against the period register clears the counter and raises a one-cycle interrupt.

An optional auto-capture copies the running count into the second register on each counting tick. In pulse mode the second register instead sets the point inside the period where the output toggles. The 16-bit registers are loaded low byte first, and the value takes effect only when the high byte is written. A low-power stop request from the chip clears the start field, and the timer stays halted until software starts it again.

Top module: `tmr16_multimode`

## Requirements
- R1: After reset the host reads 0 at every address (0 control, 1 configuration, 2/3 period low/high, 4/5 second low/high, 6/7 counter low/high), and `irq_o` and `pulse_o` are 0.
- R2: A write to a low-byte address (2 or 4) leaves the readable 16-bit register unchanged. The following high-byte write (3 or 5) commits {high byte, staged low byte} in one step.
- R3: In interval mode (configuration bits [1:0] = 0), while the start field (control bits [1:0]) is non-zero, each tick adds one to the counter. A tick that finds the counter equal to the period register instead clears it and raises `irq_o` for exactly one cycle. While the start field is 0 the counter is held at 0.
- R4: In event mode (configuration bits [1:0] = 1) the counter advances once per rising edge of `ev_i` and ignores `tick_i`.
- R5: In gated mode (configuration bits [1:0] = 2) the counter advances on `tick_i` only while `gate_i` is high.
- R6: With capture enabled (control bit 2) in modes 0, 1 or 2 while running, each counting tick stores the pre-tick count into the second register.
- R7: Capture has no effect in pulse mode or while the start field is 0.
- R8: Writes to the configuration register (address 1) are ignored while the start field is non-zero.
- R9: A cycle of `stop_i` clears the start field to 0, and counting stays halted until the host writes it again.
- R10: In pulse mode (configuration bits [1:0] = 3) `pulse_o` toggles on the tick at which the count equals the second register. It toggles again on the tick at which the count equals the period register, and that tick also clears the counter.
- R11: While stopped in pulse mode `pulse_o` shows the initial level (configuration bit 2). In every other mode `pulse_o` is 0.
- R12: Reading address 4 latches the high byte of the second register, and address 5 returns that latched byte, so the two reads together give one coherent 16-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaler tick enable |
| ev_i | input | 1 | External event pin (asynchronous) |
| gate_i | input | 1 | External gate pin (asynchronous) |
| stop_i | input | 1 | Low-power stop request |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 3 | Host register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data (combinational) |
| irq_o | output | 1 | Period-match interrupt pulse |
| pulse_o | output | 1 | Pulse-mode output level |

## Verification
The hardest case to reach from the ports is a byte-split read of the second register while its contents change between the two byte reads. The stimulus latches the high byte with a low-byte read. It then commits a different 16-bit value through the bus and reads the high byte, expecting the old byte. Pulse-mode waveforms are compared tick by tick against a bench model, using random period and toggle points with the ordering constraint respected. Random interval-mode rounds check the count and the interrupt tally against modular arithmetic.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'd0,
        MODE_EVENT    = 2'd1,
        MODE_GATED    = 2'd2,
        MODE_PULSE    = 2'd3
    } tmode_e;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CFG   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_PER_L = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_PER_H = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_SEC_L = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_SEC_H = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_CNT_L = 3'd6;
    localparam logic [ADDR_W-1:0] ADR_CNT_H = 3'd7;

    function automatic logic capture_allowed(tmode_e m);
        return (m != MODE_PULSE);
    endfunction

endpackage

// File: rtl/tmr_tick_src.sv
module tmr_tick_src
    import tmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  tmode_e mode,
    input  logic   tick_i,
    input  logic   ev_i,
    input  logic   gate_i,
    output logic   adv_o
);
    logic [2:0] ev_sync_q;
    logic [1:0] gate_sync_q;
    logic       ev_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_sync_q   <= '0;
            gate_sync_q <= '0;
        end else begin
            ev_sync_q   <= {ev_sync_q[1:0], ev_i};
            gate_sync_q <= {gate_sync_q[0], gate_i};
        end
    end

    assign ev_edge = ev_sync_q[1] & ~ev_sync_q[2];

    always_comb begin
        case (mode)
            MODE_EVENT: adv_o = ev_edge;
            MODE_GATED: adv_o = tick_i & gate_sync_q[1];
            default:    adv_o = tick_i;
        endcase
    end

    AST_EV_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ev_edge |=> !ev_edge); // R4

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int DW = DATA_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          adv,
    input  tmode_e        mode,
    input  logic          cap_en,
    input  logic          ff_init,
    input  logic [DW-1:0] per,
    input  logic [DW-1:0] sec,
    output logic [DW-1:0] cnt_o,
    output logic          irq_o,
    output logic          ff_o,
    output logic          cap_vld_o,
    output logic [DW-1:0] cap_val_o
);
    logic [DW-1:0] cnt_q;
    logic          irq_q;
    logic          ff_q;
    logic          is_pulse;

    assign is_pulse = (mode == MODE_PULSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
            ff_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (!run) begin
                cnt_q <= '0;
                ff_q  <= is_pulse ? ff_init : 1'b0;
            end else if (adv) begin
                if (cnt_q == per) begin
                    cnt_q <= '0;
                    irq_q <= 1'b1;
                    if (is_pulse) ff_q <= ~ff_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    if (is_pulse && cnt_q == sec) ff_q <= ~ff_q;
                end
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign irq_o     = irq_q;
    assign ff_o      = ff_q;
    assign cap_vld_o = run & adv & cap_en & capture_allowed(mode);
    assign cap_val_o = cnt_q;

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (cnt_q == '0)); // R3

    AST_FF_LOW_OUTSIDE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_PULSE) |=> !ff_q); // R11

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int BW = BYTE_W,
    parameter int AW = ADDR_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rdata,
    input  logic          stop_i,
    input  logic          cap_vld,
    input  logic [DW-1:0] cap_val,
    input  logic [DW-1:0] cnt,
    output logic [1:0]    start_o,
    output logic          cap_en_o,
    output tmode_e        mode_o,
    output logic          ff_init_o,
    output logic [DW-1:0] per_o,
    output logic [DW-1:0] sec_o
);
    logic [1:0]    start_q;
    logic          cap_en_q;
    tmode_e        mode_q;
    logic          ff_init_q;
    logic [BW-1:0] stage_q;
    logic [DW-1:0] per_q;
    logic [DW-1:0] sec_q;
    logic [BW-1:0] sec_hi_lat_q;

    logic wr_ctrl, wr_cfg, wr_lo, wr_per_h, wr_sec_h;

    assign wr_ctrl  = wr_en && addr == ADR_CTRL;
    assign wr_cfg   = wr_en && addr == ADR_CFG;
    assign wr_lo    = wr_en && (addr == ADR_PER_L || addr == ADR_SEC_L);
    assign wr_per_h = wr_en && addr == ADR_PER_H;
    assign wr_sec_h = wr_en && addr == ADR_SEC_H;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q      <= '0;
            cap_en_q     <= 1'b0;
            mode_q       <= MODE_INTERVAL;
            ff_init_q    <= 1'b0;
            stage_q      <= '0;
            per_q        <= '0;
            sec_q        <= '0;
            sec_hi_lat_q <= '0;
        end else begin
            if (stop_i) begin
                start_q <= '0;
            end else if (wr_ctrl) begin
                start_q <= wdata[1:0];
            end
            if (wr_ctrl) cap_en_q <= wdata[2];
            if (wr_cfg && start_q == 2'b00) begin
                mode_q    <= tmode_e'(wdata[1:0]);
                ff_init_q <= wdata[2];
            end
            if (wr_lo) stage_q <= wdata;
            if (wr_per_h) per_q <= {wdata, stage_q};
            if (wr_sec_h) begin
                sec_q <= {wdata, stage_q};
            end else if (cap_vld) begin
                sec_q <= cap_val;
            end
            if (rd_en && addr == ADR_SEC_L) sec_hi_lat_q <= sec_q[DW-1:BW];
        end
    end

    always_comb begin
        case (addr)
            ADR_CTRL:  rdata = {5'b0, cap_en_q, start_q};
            ADR_CFG:   rdata = {5'b0, ff_init_q, mode_q};
            ADR_PER_L: rdata = per_q[BW-1:0];
            ADR_PER_H: rdata = per_q[DW-1:BW];
            ADR_SEC_L: rdata = sec_q[BW-1:0];
            ADR_SEC_H: rdata = sec_hi_lat_q;
            ADR_CNT_L: rdata = cnt[BW-1:0];
            default:   rdata = cnt[DW-1:BW];
        endcase
    end

    assign start_o   = start_q;
    assign cap_en_o  = cap_en_q;
    assign mode_o    = mode_q;
    assign ff_init_o = ff_init_q;
    assign per_o     = per_q;
    assign sec_o     = sec_q;

    AST_LO_WRITE_HOLDS_PER: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_PER_L) |=> $stable(per_q)); // R2

    AST_STOP_CLEARS_START: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> (start_q == 2'b00)); // R9

    AST_CFG_LOCKED_RUNNING: assert property (@(posedge clk) disable iff (rst)
        (start_q != 2'b00) |=> $stable(mode_q)); // R8

endmodule

// File: rtl/tmr16_multimode.sv
module tmr16_multimode
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              ev_i,
    input  logic              gate_i,
    input  logic              stop_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              pulse_o
);
    logic [1:0]        start;
    logic              cap_en;
    tmode_e            mode;
    logic              ff_init;
    logic [DATA_W-1:0] per, sec, cnt, cap_val;
    logic              cap_vld, adv, run;

    assign run = (start != 2'b00);

    tmr_regs #(.DW(DATA_W), .BW(BYTE_W), .AW(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en_i), .rd_en(rd_en_i),
        .addr(addr_i), .wdata(wdata_i), .rdata(rdata_o), .stop_i(stop_i),
        .cap_vld(cap_vld), .cap_val(cap_val), .cnt(cnt),
        .start_o(start), .cap_en_o(cap_en), .mode_o(mode),
        .ff_init_o(ff_init), .per_o(per), .sec_o(sec)
    );

    tmr_tick_src tick_i0 (
        .clk(clk), .rst(rst), .mode(mode), .tick_i(tick_i),
        .ev_i(ev_i), .gate_i(gate_i), .adv_o(adv)
    );

    tmr_core #(.DW(DATA_W)) core_i (
        .clk(clk), .rst(rst), .run(run), .adv(adv), .mode(mode),
        .cap_en(cap_en), .ff_init(ff_init), .per(per), .sec(sec),
        .cnt_o(cnt), .irq_o(irq_o), .ff_o(pulse_o),
        .cap_vld_o(cap_vld), .cap_val_o(cap_val)
    );

endmodule

// File: tb/tmr16_multimode_tb_top.sv
module tmr16_multimode_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, ev = 1'b0, gate = 1'b0, stop = 1'b0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    tmr16_multimode dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .ev_i(ev), .gate_i(gate),
        .stop_i(stop), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .pulse_o(pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_b(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic rd_b(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #2 d = rdata;
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
        wr_b(lo, v[7:0]);
        wr_b(lo + 3'd1, v[15:8]);
    endtask

    task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd_b(lo, l);
        rd_b(lo + 3'd1, h);
        v = {h, l};
    endtask

    task automatic do_tick(output logic i, output logic p);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        #1 i = irq; p = pulse;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // mode 0..3 in cfg bits [1:0], initial level in bit 2
    task automatic setup(input logic [1:0] m, input logic ffi,
                         input logic [15:0] per_v, input logic [15:0] sec_v);
        wr_b(3'd0, 8'h00);
        wr_b(3'd1, {5'b0, ffi, m});
        wr16(3'd2, per_v);
        wr16(3'd4, sec_v);
    endtask

    function automatic logic [15:0] exp_cnt(input int t, input int per_v);
        return 16'(t % (per_v + 1));
    endfunction

    function automatic int exp_irqs(input int t, input int per_v);
        return t / (per_v + 1);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        logic        i, p;
        int          irqs;
        void'($urandom(32'h5EED_0042));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd_b(3'(a), b);
            chk("R1 reset register", {24'b0, b}, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 pulse after reset", {31'b0, pulse}, 32'h0);

        // R2 byte-ordered commit
        wr_b(3'd2, 8'h34);
        rd16(3'd2, v);
        chk("R2 low byte alone", {16'b0, v}, 32'h0);
        wr_b(3'd3, 8'h12);
        rd16(3'd2, v);
        chk("R2 commit on high byte", {16'b0, v}, 32'h1234);

        // R3 directed: period 3, four ticks, one-cycle irq
        setup(2'd0, 1'b0, 16'd3, 16'd0);
        wr_b(3'd0, 8'h01);
        for (int k = 0; k < 3; k++) do_tick(i, p);
        chk("R3 no irq before match", {31'b0, i}, 32'h0);
        do_tick(i, p);
        chk("R3 irq on match", {31'b0, i}, 32'h1);
        @(negedge clk); #1;
        chk("R3 irq one cycle", {31'b0, irq}, 32'h0);
        rd16(3'd6, v);
        chk("R3 counter cleared", {16'b0, v}, 32'h0);

        // R3 random rounds
        for (int r = 0; r < 12; r++) begin
            int per_v, t;
            per_v = 2 + int'($urandom_range(0, 9));
            t     = 5 + int'($urandom_range(0, 40));
            setup(2'd0, 1'b0, 16'(per_v), 16'd0);
            wr_b(3'd0, 8'h01);
            irqs = 0;
            for (int k = 0; k < t; k++) begin
                do_tick(i, p);
                if (i) irqs++;
            end
            rd16(3'd6, v);
            chk("R3 random count", {16'b0, v}, {16'b0, exp_cnt(t, per_v)});
            chk("R3 random irq total", irqs, exp_irqs(t, per_v));
        end

        // R8 configuration locked while running
        wr_b(3'd1, 8'h02);
        rd_b(3'd1, b);
        chk("R8 cfg ignored while running", {24'b0, b}, 32'h0);

        // R9 stop input
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        rd_b(3'd0, b);
        chk("R9 start cleared by stop", {30'b0, b[1:0]}, 32'h0);
        for (int k = 0; k < 4; k++) do_tick(i, p);
        rd16(3'd6, v);
        chk("R9 no counting after stop", {16'b0, v}, 32'h0);

        // R7 capture while stopped, then R6 capture while running
        setup(2'd0, 1'b0, 16'h0100, 16'hBEEF);
        wr_b(3'd0, 8'h04);
        for (int k = 0; k < 3; k++) do_tick(i, p);
        rd16(3'd4, v);
        chk("R7 no capture while stopped", {16'b0, v}, 32'hBEEF);
        wr_b(3'd0, 8'h05);
        for (int k = 0; k < 7; k++) do_tick(i, p);
        rd16(3'd4, v);
        chk("R6 captured pre-tick count", {16'b0, v}, 32'd6);

        // R12 coherent read of second register
        wr_b(3'd0, 8'h00);
        wr16(3'd4, 16'h12AB);
        rd_b(3'd4, b);
        chk("R12 low byte", {24'b0, b}, 32'hAB);
        wr16(3'd4, 16'h34CD);
        rd_b(3'd5, b);
        chk("R12 latched high byte", {24'b0, b}, 32'h12);

        // R4 event mode, prescaler tick held high and ignored
        setup(2'd1, 1'b0, 16'hFFFF, 16'd0);
        wr_b(3'd0, 8'h01);
        @(negedge clk); tick = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); ev = 1'b1;
            idle(3);
            ev = 1'b0;
            idle(3);
        end
        tick = 1'b0;
        idle(4);
        rd16(3'd6, v);
        chk("R4 event edges counted", {16'b0, v}, 32'd6);

        // R5 gated mode
        setup(2'd2, 1'b0, 16'hFFFF, 16'd0);
        wr_b(3'd0, 8'h01);
        gate = 1'b1; idle(4);
        for (int k = 0; k < 5; k++) do_tick(i, p);
        gate = 1'b0; idle(4);
        for (int k = 0; k < 4; k++) do_tick(i, p);
        rd16(3'd6, v);
        chk("R5 gated ticks only", {16'b0, v}, 32'd5);

        // R11 level forced low outside pulse mode
        setup(2'd0, 1'b1, 16'd4, 16'd2);
        idle(2); #1;
        chk("R11 low while stopped non-pulse", {31'b0, pulse}, 32'h0);
        wr_b(3'd0, 8'h01);
        do_tick(i, p);
        chk("R11 low while running non-pulse", {31'b0, p}, 32'h0);

        // R10/R7/R11 pulse mode random rounds
        for (int r = 0; r < 8; r++) begin
            int per_v, sec_v, mc;
            logic lvl, ml;
            per_v = 3 + int'($urandom_range(0, 8));
            sec_v = 2 + int'($urandom_range(0, per_v - 3));
            lvl   = 1'($urandom_range(0, 1));
            setup(2'd3, lvl, 16'(per_v), 16'(sec_v));
            idle(2); #1;
            chk("R11 initial level while stopped", {31'b0, pulse}, {31'b0, lvl});
            wr_b(3'd0, 8'h05);
            mc = 0; ml = lvl;
            for (int k = 0; k < 2 * (per_v + 1) + 3; k++) begin
                logic mi;
                mi = 1'b0;
                if (mc == per_v) begin
                    mc = 0; ml = ~ml; mi = 1'b1;
                end else begin
                    if (mc == sec_v) ml = ~ml;
                    mc++;
                end
                do_tick(i, p);
                chk("R10 pulse level", {31'b0, p}, {31'b0, ml});
                chk("R10 pulse irq", {31'b0, i}, {31'b0, mi});
            end
            rd16(3'd4, v);
            chk("R7 no capture in pulse mode", {16'b0, v}, sec_v);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule